// File: doc/BRIEF.md
# Line-Activity Watchdog Timer

This block guards a processor by watching one signal line for signs of life. The line can be a dedicated kick pin or the data line of a serial memory bus. Every rising or falling transition on the line restarts an idle timer. If the line stays still for the whole timeout, which defaults to 1.6 seconds, the block sends a single-cycle reset request to the reset controller.

The line is asynchronous to the block's clock, so it first passes through a synchronizer chain. A one-flop edge detector then finds transitions in both directions. The timeout is set in milliseconds together with the clock frequency, and the block turns these into a cycle count. While the system reset is active, the whole block is frozen with the timer at zero. The reset controller is expected to answer a request by asserting reset, and that keeps the timer cleared until reset is released. The block has no data stream, so its pins are plain control signals with no valid/ready handshake.

Top module: `activity_watchdog`

## Requirements
- R1: With the line held at its idle level through reset release, `wd_expire` goes high in the cycle after the TIMEOUT_CYC-th rising clock edge that follows release. The first edge after release is edge 1, and the count starts from zero on that edge.
- R2: `wd_expire` is high for exactly one clock cycle. If the line stays inactive and reset is not asserted, another pulse follows every TIMEOUT_CYC edges, so the second pulse comes at edge 2*TIMEOUT_CYC.
- R3: A rising transition on the line clears the timer. If the line changes before edge k, the next pulse comes after edge k+2+TIMEOUT_CYC: two edges to synchronize, one to detect, then a full timeout.
- R4: A falling transition clears the timer with the same timing as a rising one.
- R5: A transition is seen in the very cycle in which the count reaches TIMEOUT_CYC-1 (a line change before edge TIMEOUT_CYC-2 after release). In that case the clear wins, no pulse is sent at edge TIMEOUT_CYC, and the next pulse comes at edge 2*TIMEOUT_CYC.
- R6: A transition that is seen one cycle too late to stop the expiry (a line change before edge TIMEOUT_CYC-1) does not cancel the pulse at edge TIMEOUT_CYC. It then restarts the timer, and the second pulse comes at edge 2*TIMEOUT_CYC+1.
- R7: While `rst_n` is low, `wd_expire` stays low and the timer is held at zero. Line transitions during reset have no effect. After release the full timeout applies again, counted from zero.
- R8: The internal count never goes above TIMEOUT_CYC-1.
- R9: TIMEOUT_CYC equals CLK_HZ*TIMEOUT_MS/1000. The synchronizer and edge-detector flops reset to LINE_IDLE, so a line sitting at that level at release does not count as a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert; freezes and clears the timer |
| mon_line | input | 1 | Monitored line (kick pin or serial data), asynchronous |
| wd_expire | output | 1 | One-cycle reset request when the idle timeout elapses |

## Verification
Two events can fall in the same cycle: a line transition reaching the edge detector, and the timer reaching its last count. The bench provokes this by placing a transition at the exact cycle that R5 gives, where the clear must suppress the pulse. It then moves the transition one cycle later, which is the R6 case where the pulse must still be sent. In both cases the bench records the edge index of the first and second pulse, compares them with values worked out from TIMEOUT_CYC, and requires every pulse to last a single cycle.

// File: rtl/wd_pkg.sv
package wd_pkg;

  // Converts a time in milliseconds into a count of clock cycles.
  // The arithmetic is done in 64 bits so that the product cannot overflow.
  function automatic int unsigned ms_to_cycles(longint unsigned hz, longint unsigned ms);
    longint unsigned prod;
    prod = (hz * ms) / 64'd1000;
    return int'(prod);
  endfunction

  // Number of bits needed to hold a count from 0 to n-1.
  function automatic int unsigned count_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RST_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/wd_edge.sv
module wd_edge #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic toggled
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  // Transitions in either direction count as activity.
  assign rise    = level & ~prev_q;
  assign fall    = ~level & prev_q;
  assign toggled = rise | fall;

endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned CW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          expire
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic at_last;
  logic fire;

  assign at_last = (count == LAST);
  // A clear in the same cycle as the last count takes priority over expiry.
  assign fire    = at_last & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear || at_last) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expire <= 1'b0;
    else        expire <= fire;
  end

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wd_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter bit              LINE_IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_line,
  output logic wd_expire
);

  localparam int unsigned TIMEOUT_CYC = ms_to_cycles(CLK_HZ, TIMEOUT_MS);
  localparam int unsigned CW          = count_width(TIMEOUT_CYC);

  logic          line_sync;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  wd_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (mon_line),
    .dout (line_sync)
  );

  wd_edge #(
    .RST_VAL(LINE_IDLE)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (line_sync),
    .toggled(edge_seen)
  );

  wd_timer #(
    .LIMIT(TIMEOUT_CYC),
    .CW   (CW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (edge_seen),
    .count (cnt),
    .expire(wd_expire)
  );

endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned CW    = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_seen,
  input logic [CW-1:0] cnt,
  input logic          wd_expire
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  // R2: a request lasts one cycle.
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !wd_expire);

  // R8: the count stays below the limit.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R3 / R4: a detected transition empties the timer.
  assert_edge_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (cnt == '0));

  // R5: a transition in the final cycle blocks the request.
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !wd_expire);

  // R1: a request only follows the last count.
  assert_expire_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> ($past(cnt) == LAST));

  // R1: without activity the count advances by one each cycle.
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt != LAST) |=> (cnt == CW'($past(cnt) + 1'b1)));

endmodule

bind activity_watchdog wd_checker #(
  .LIMIT(TIMEOUT_CYC),
  .CW   (CW)
) u_wd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_seen(edge_seen),
  .cnt      (cnt),
  .wd_expire(wd_expire)
);

// File: tb/activity_watchdog_test.sv
module activity_watchdog_test;

  localparam longint unsigned CLK_HZ     = 20_000;
  localparam longint unsigned TIMEOUT_MS = 1;
  localparam bit              IDLE       = 1'b0;
  localparam int              LIM        = int'(CLK_HZ * TIMEOUT_MS / 1000); // R9
  localparam int              WINDOW     = 3 * LIM + 5;

  typedef struct packed {
    int ta;   // edge index before which the line toggles first (0 = never)
    int tb;   // edge index of second toggle (0 = never)
    int e1;   // expected edge of first pulse
    int e2;   // expected edge of second pulse
    int req;  // requirement number for messages
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{0,       0,       LIM,      2*LIM,     1}, // R1 and R2: no activity
    '{1,       0,       LIM+3,    2*LIM+3,   3}, // R3: early rise
    '{5,       0,       LIM+7,    2*LIM+7,   3}, // R3: later rise
    '{2,       10,      LIM+12,   2*LIM+12,  4}, // R4: rise then fall
    '{LIM-2,   0,       2*LIM,    3*LIM,     5}, // R5: clear meets last count
    '{LIM-1,   0,       LIM,      2*LIM+1,   6}  // R6: one cycle late
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_line = IDLE;
  logic wd_expire;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  activity_watchdog #(
    .CLK_HZ    (CLK_HZ),
    .TIMEOUT_MS(TIMEOUT_MS),
    .LINE_IDLE (IDLE)
  ) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_line (mon_line),
    .wd_expire(wd_expire)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mon_line = IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Watches WINDOW edges after release, toggling the line as requested.
  task automatic run_window(input int ta, input int tb,
                            output int p1, output int p2, output bit wide);
    bit last = 1'b0;
    p1 = 0; p2 = 0; wide = 1'b0;
    for (int c = 1; c <= WINDOW; c++) begin
      if (c == ta || c == tb) mon_line = ~mon_line;
      @(posedge clk);
      @(negedge clk);
      if (wd_expire) begin
        if (last) wide = 1'b1;
        if (p1 == 0) p1 = c;
        else if (p2 == 0) p2 = c;
      end
      last = wd_expire;
    end
  endtask

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int p1, p2;
    bit wide;

    // R7: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(wd_expire == 1'b0, 7, "output during reset", wd_expire, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_window(VECS[v].ta, VECS[v].tb, p1, p2, wide);
      check(p1 == VECS[v].e1, VECS[v].req, "first pulse edge", p1, VECS[v].e1);
      check(p2 == VECS[v].e2, VECS[v].req, "second pulse edge", p2, VECS[v].e2);
      check(!wide, 2, "pulse width one cycle", wide, 0);
    end

    // R7: reset mid-count, line active during reset, then full timeout again
    begin
      bit seen = 1'b0;
      do_reset();
      repeat (12) @(negedge clk);
      rst_n = 1'b0;
      for (int c = 0; c < 3 * LIM; c++) begin
        mon_line = ~mon_line;
        @(negedge clk);
        if (wd_expire) seen = 1'b1;
      end
      check(!seen, 7, "pulse while reset held", seen, 0);
      mon_line = IDLE;
      @(negedge clk);
      rst_n = 1'b1;
      run_window(0, 0, p1, p2, wide);
      check(p1 == LIM, 7, "first pulse after release", p1, LIM);
      check(p2 == 2 * LIM, 2, "repeat pulse after release", p2, 2 * LIM);
    end

    // R9: idle level at release yields no transition, timeout from params
    do_reset();
    run_window(0, 0, p1, p2, wide);
    check(p1 == LIM, 9, "timeout equals CLK_HZ*TIMEOUT_MS/1000", p1, LIM);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule